// File: doc/BRIEF.md
# Two-Wire Serial Bus Control-Signal Engine

This block handles the control signalling of a two-wire serial bus with one clock line and one bidirectional open-drain data line. It works beside an external byte shifter and clock source. It watches the synchronized bus for data-line edges while the clock is high. A rising edge there marks a bus release. A falling edge marks a command. The block keeps flags for both conditions and uses them to label each received byte as an address or a command.

In master role, software pulses let it produce the release and command conditions itself. A load strobe starts a byte transmission, with bits taken one at a time from the external shifter. In the ninth clock slot it either watches for the remote acknowledge or drives its own. The acknowledge can be automatic or triggered by software. In slave role it can then hold the data line low as a busy indication until software drops the busy enable.

One of several data pins is selected as the active pin. The pins that are not selected are never driven.

Top module: `sbus_ctl_engine`

## Requirements
- R1: A rising edge of the selected data line while the clock line is high, seen on two consecutive synchronized samples, sets `flag_rel` and clears `flag_cmd`.
- R2: A falling edge of the selected data line while the clock line is high sets `flag_cmd`.
- R3: Data-line changes while the clock line is low change neither `flag_rel` nor `flag_cmd`.
- R4: In master role (`role_master`=1), a `trig_cmd` pulse pulls the data line low. A `trig_rel` pulse produces a one-cycle low followed by a release, which is a rising edge. In slave role both triggers have no effect on the outputs.
- R5: After `tx_load`, the engine drives each bit on a clock falling edge, most significant bit first. A 0 bit is driven low (output enable 1) and a 1 bit is released. One `sh_advance` pulse follows each driven bit, for 8 bits.
- R6: When transmitting, a low data line at the ninth rising clock edge sets `flag_ack`. `tx_load` clears `flag_ack`.
- R7: When receiving with `ack_auto_en`=1, the engine drives the data line low from the eighth clock falling edge to the ninth, and only for that slot.
- R8: With `ack_auto_en`=0, the acknowledge is driven only if `trig_ack` was pulsed during the byte. Otherwise the line stays released in the ninth slot.
- R9: In slave role with `busy_en`=1, the line is held low from the ninth falling clock edge until `busy_en` returns to 0. After that it is released (ready level).
- R10: `byte_done` pulses once per 8 received bits. `byte_is_addr` is 1 if both a release and a command were seen since the previous byte, and 0 if only a command was seen. A completed byte clears `flag_rel`.
- R11: `sda_oe` bit i can be 1 only when `pin_sel`=i. All enables are 0 after reset. Only `sda_in[pin_sel]` is observed.
- R12: Each of the 8 data bits is sampled at a clock rising edge and presented on `rx_bit` with an `rx_strobe` pulse, first bit received first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| pin_sel | input | $clog2(PINS) | Index of the active data pin |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | PINS | Raw data line levels |
| sda_oe | output | PINS | Open-drain pull-low enables |
| ack_auto_en | input | 1 | Automatic acknowledge enable |
| busy_en | input | 1 | Busy hold enable (slave) |
| trig_rel | input | 1 | Pulse: generate release condition (master) |
| trig_cmd | input | 1 | Pulse: generate command condition (master) |
| trig_ack | input | 1 | Pulse: acknowledge the current byte |
| tx_load | input | 1 | Pulse: transmit byte loaded, start transfer |
| sh_tx_bit | input | 1 | Next bit to send from the external shifter |
| sh_advance | output | 1 | Pulse: shifter may present the following bit |
| rx_strobe | output | 1 | Pulse: `rx_bit` is valid |
| rx_bit | output | 1 | Sampled data bit |
| byte_done | output | 1 | Pulse: 8 bits received |
| byte_is_addr | output | 1 | Tag of the completed byte (1 = address) |
| flag_rel | output | 1 | Release condition seen |
| flag_cmd | output | 1 | Command condition seen |
| flag_ack | output | 1 | Acknowledge detected by transmitter |

## Verification
The ninth falling clock edge is where two functions meet. In the same cycle the acknowledge drive ends and the busy drive begins, so a fault in either shows as a release of the line that should not happen, or as a line that stays low. The bench judges this by sampling the enable in the ninth slot, after that edge, and again after `busy_en` is dropped. A second overlap is the master's release trigger: it makes a command edge and a release edge back to back. The bench drives it from a command-flag-set state and checks that the flags end as release set and command clear.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   // Synchronized bus events, valid for one system clock
   typedef struct packed {
      logic rise;   // clock line went high
      logic fall;   // clock line went low
      logic rel;    // data rose while clock high
      logic cmd;    // data fell while clock high
   } bus_evt_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("sbus_sync needs at least two stages");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[0], d};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sbus_cond_det.sv
module sbus_cond_det
   import sbus_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);
   logic scl_d, sda_d;

   // idle bus is pulled high, so history resets high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_comb begin
      evt.rise = scl_s & ~scl_d;
      evt.fall = ~scl_s & scl_d;
      // qualify against a clock level that held high on both samples
      evt.rel  = scl_s & scl_d & sda_s & ~sda_d;
      evt.cmd  = scl_s & scl_d & ~sda_s & sda_d;
   end
endmodule

// File: rtl/sbus_slot_seq.sv
module sbus_slot_seq
   import sbus_pkg::*;
#(
   parameter int unsigned BYTE_BITS = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  bus_evt_t evt,
   input  logic     sda_s,
   input  logic     role_master,
   input  logic     ack_auto_en,
   input  logic     busy_en,
   input  logic     trig_ack,
   input  logic     tx_load,
   input  logic     sh_tx_bit,
   output logic     drv_lo,
   output logic     drv_busy,
   output logic     sh_advance,
   output logic     rx_strobe,
   output logic     rx_bit,
   output logic     bd_pulse,
   output logic     ack_seen
);
   localparam int unsigned CW        = $clog2(BYTE_BITS + 2);
   localparam logic [CW-1:0] LAST_D  = CW'(BYTE_BITS - 1);
   localparam logic [CW-1:0] ACK_SL  = CW'(BYTE_BITS);
   localparam logic [CW-1:0] TAIL    = CW'(BYTE_BITS + 1);

   logic [CW-1:0] cnt;
   logic          tx_active, ack_pend;
   logic          drv_data, drv_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         tx_active  <= 1'b0;
         ack_pend   <= 1'b0;
         drv_data   <= 1'b0;
         drv_ack    <= 1'b0;
         drv_busy   <= 1'b0;
         sh_advance <= 1'b0;
         rx_strobe  <= 1'b0;
         rx_bit     <= 1'b0;
         bd_pulse   <= 1'b0;
         ack_seen   <= 1'b0;
      end else begin
         sh_advance <= 1'b0;
         rx_strobe  <= 1'b0;
         bd_pulse   <= 1'b0;
         ack_seen   <= 1'b0;

         if (trig_ack) ack_pend <= 1'b1;

         if (evt.rel || evt.cmd) begin
            cnt      <= '0;
            drv_data <= 1'b0;
            drv_ack  <= 1'b0;
         end

         if (tx_load) begin
            tx_active <= 1'b1;
            cnt       <= '0;
         end

         if (evt.fall) begin
            if (tx_active && cnt < ACK_SL) begin
               drv_data   <= ~sh_tx_bit;
               sh_advance <= 1'b1;
            end else begin
               drv_data <= 1'b0;
            end
            if (cnt == ACK_SL && !tx_active && (ack_auto_en || ack_pend)) begin
               drv_ack  <= 1'b1;
               ack_pend <= 1'b0;
            end
            if (cnt == TAIL) begin
               cnt       <= '0;
               drv_ack   <= 1'b0;
               tx_active <= 1'b0;
               ack_pend  <= 1'b0;
               if (busy_en && !role_master) drv_busy <= 1'b1;
            end
         end

         if (evt.rise && cnt <= ACK_SL) begin
            cnt <= cnt + 1'b1;
            if (cnt < ACK_SL) begin
               rx_strobe <= 1'b1;
               rx_bit    <= sda_s;
            end
            if (cnt == LAST_D) bd_pulse <= 1'b1;
            if (cnt == ACK_SL && tx_active && !sda_s) ack_seen <= 1'b1;
         end

         if (!busy_en) drv_busy <= 1'b0;
      end
   end

   assign drv_lo = drv_data | drv_ack | drv_busy;
endmodule

// File: rtl/sbus_ctl_engine.sv
module sbus_ctl_engine
   import sbus_pkg::*;
#(
   parameter  int unsigned PINS        = 2,
   parameter  int unsigned SYNC_STAGES = 2,
   parameter  int unsigned BYTE_BITS   = 8,
   localparam int unsigned SELW        = (PINS > 1) ? $clog2(PINS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            role_master,
   input  logic [SELW-1:0] pin_sel,
   input  logic            scl_in,
   input  logic [PINS-1:0] sda_in,
   output logic [PINS-1:0] sda_oe,
   input  logic            ack_auto_en,
   input  logic            busy_en,
   input  logic            trig_rel,
   input  logic            trig_cmd,
   input  logic            trig_ack,
   input  logic            tx_load,
   input  logic            sh_tx_bit,
   output logic            sh_advance,
   output logic            rx_strobe,
   output logic            rx_bit,
   output logic            byte_done,
   output logic            byte_is_addr,
   output logic            flag_rel,
   output logic            flag_cmd,
   output logic            flag_ack
);
   generate
      if (PINS < 2) begin : g_bad_pins
         $error("sbus_ctl_engine needs at least two data pins");
      end
      if (BYTE_BITS < 2) begin : g_bad_bits
         $error("sbus_ctl_engine needs at least two bits per byte");
      end
   endgenerate

   logic     sda_mux, scl_s, sda_s;
   bus_evt_t ev;
   logic     ev_rel, ev_cmd, ev_rise;
   logic     seq_lo, drv_busy, bd_pulse, ack_seen;
   logic     gen_lo, rel_step, line_lo;

   assign sda_mux = sda_in[pin_sel];

   sbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   sbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_mux), .q(sda_s));

   sbus_cond_det u_det (.clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt(ev));

   assign ev_rel  = ev.rel;
   assign ev_cmd  = ev.cmd;
   assign ev_rise = ev.rise;

   sbus_slot_seq #(.BYTE_BITS(BYTE_BITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .evt(ev), .sda_s(sda_s),
      .role_master(role_master), .ack_auto_en(ack_auto_en), .busy_en(busy_en),
      .trig_ack(trig_ack), .tx_load(tx_load), .sh_tx_bit(sh_tx_bit),
      .drv_lo(seq_lo), .drv_busy(drv_busy), .sh_advance(sh_advance),
      .rx_strobe(rx_strobe), .rx_bit(rx_bit), .bd_pulse(bd_pulse), .ack_seen(ack_seen));

   // master-side condition generator; the bus clock is assumed high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_lo   <= 1'b0;
         rel_step <= 1'b0;
      end else if (role_master && trig_cmd) begin
         gen_lo   <= 1'b1;
         rel_step <= 1'b0;
      end else if (role_master && trig_rel) begin
         gen_lo   <= 1'b1;   // guarantee a low before the release edge
         rel_step <= 1'b1;
      end else if (rel_step) begin
         gen_lo   <= 1'b0;
         rel_step <= 1'b0;
      end else if (ev.fall) begin
         gen_lo   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_rel     <= 1'b0;
         flag_cmd     <= 1'b0;
         flag_ack     <= 1'b0;
         byte_done    <= 1'b0;
         byte_is_addr <= 1'b0;
      end else begin
         byte_done <= bd_pulse;
         if (bd_pulse) begin
            byte_is_addr <= flag_rel & flag_cmd;
            flag_rel     <= 1'b0;
         end
         if (ev_rel) begin
            flag_rel <= 1'b1;
            flag_cmd <= 1'b0;
         end
         if (ev_cmd) flag_cmd <= 1'b1;
         if (ack_seen) flag_ack <= 1'b1;
         if (tx_load)  flag_ack <= 1'b0;
      end
   end

   assign line_lo = seq_lo | gen_lo;

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      assign sda_oe[i] = line_lo && (pin_sel == SELW'(i));
   end
endmodule

// File: rtl/sbus_ctl_engine_chk.sv
module sbus_ctl_engine_chk #(
   parameter int unsigned PINS = 2,
   parameter int unsigned SELW = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PINS-1:0] sda_oe,
   input logic [SELW-1:0] pin_sel,
   input logic            ev_rel,
   input logic            ev_cmd,
   input logic            ev_rise,
   input logic            flag_rel,
   input logic            flag_cmd,
   input logic            flag_ack,
   input logic            busy_en,
   input logic            drv_busy,
   input logic            tx_load
);
   p_rel_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rel |=> (flag_rel && !flag_cmd));

   p_cmd_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cmd |=> flag_cmd);

   p_ack_after_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_ack) |-> $past(ev_rise, 2));

   p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !flag_ack);

   p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_en |=> !drv_busy);

   p_pin_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((sda_oe & ~(PINS'(1) << pin_sel)) == '0) && $onehot0(sda_oe));
endmodule

bind sbus_ctl_engine sbus_ctl_engine_chk #(.PINS(PINS), .SELW(SELW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .pin_sel(pin_sel),
   .ev_rel(ev_rel), .ev_cmd(ev_cmd), .ev_rise(ev_rise),
   .flag_rel(flag_rel), .flag_cmd(flag_cmd), .flag_ack(flag_ack),
   .busy_en(busy_en), .drv_busy(drv_busy), .tx_load(tx_load));

// File: tb/sbus_ctl_engine_tb.sv
module sbus_ctl_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HP = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       role_master = 1'b0, pin_sel = 1'b0, tb_scl = 1'b1;
   logic [1:0] tb_lo = 2'b00;
   logic [1:0] sda_in, sda_oe;
   logic       ack_auto_en = 1'b1, busy_en = 1'b1;
   logic       trig_rel = 1'b0, trig_cmd = 1'b0, trig_ack = 1'b0, tx_load = 1'b0;
   logic       sh_tx_bit, sh_advance, rx_strobe, rx_bit, byte_done, byte_is_addr;
   logic       flag_rel, flag_cmd, flag_ack;

   assign sda_in = ~(sda_oe | tb_lo);

   sbus_ctl_engine dut_i (
      .clk(clk), .rst_n(rst_n), .role_master(role_master), .pin_sel(pin_sel),
      .scl_in(tb_scl), .sda_in(sda_in), .sda_oe(sda_oe),
      .ack_auto_en(ack_auto_en), .busy_en(busy_en),
      .trig_rel(trig_rel), .trig_cmd(trig_cmd), .trig_ack(trig_ack),
      .tx_load(tx_load), .sh_tx_bit(sh_tx_bit), .sh_advance(sh_advance),
      .rx_strobe(rx_strobe), .rx_bit(rx_bit), .byte_done(byte_done),
      .byte_is_addr(byte_is_addr), .flag_rel(flag_rel), .flag_cmd(flag_cmd),
      .flag_ack(flag_ack));

   int n_chk = 0, n_fail = 0, adv = 0;
   bit finished = 1'b0;
   logic [7:0] tx_shadow = 8'h00, rx_acc = 8'h00;
   logic [8:0] sb_q[$];   // {expected tag, expected byte}

   assign sh_tx_bit = (adv < 8) ? tx_shadow[3'(7 - adv)] : 1'b1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic wait_half();
      repeat (HP) @(negedge clk);
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; @(negedge clk); s = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (tx_load) adv = 0;
      if (sh_advance) adv++;
      if (rx_strobe) rx_acc = {rx_acc[6:0], rx_bit};
      if (byte_done) begin
         if (sb_q.size() == 0) chk(1'b0, "R10 unexpected byte", 32'(rx_acc), 32'h0);
         else begin
            logic [8:0] e;
            e = sb_q.pop_front();
            chk(rx_acc == e[7:0], "R12 received byte", 32'(rx_acc), 32'(e[7:0]));
            chk(byte_is_addr == e[8], "R10 byte tag", 32'(byte_is_addr), 32'(e[8]));
         end
      end
   end

   // slave reception of 8 bits, clock left high
   task automatic slave_bits(input logic [7:0] b, input logic tag);
      sb_q.push_back({tag, b});
      for (int i = 7; i >= 0; i--) begin
         tb_scl = 1'b0; wait_half();
         tb_lo[0] = ~b[i]; wait_half();
         tb_scl = 1'b1; wait_half();
      end
   endtask

   // master transmit of 8 bits, checking the line at each high clock
   task automatic master_bits(input logic [7:0] b, input logic tag);
      tx_shadow = b;
      sb_q.push_back({tag, b});
      pulse(tx_load);
      for (int i = 7; i >= 0; i--) begin
         tb_scl = 1'b0; wait_half();
         tb_scl = 1'b1; wait_half();
         chk(sda_in[1] == b[i], "R5 master bit on line", 32'(sda_in[1]), 32'(b[i]));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(sda_oe == 2'b00, "R11 reset enables", 32'(sda_oe), 32'h0);
      chk({flag_rel, flag_cmd, flag_ack} == 3'b000, "R1 reset flags", 32'({flag_rel, flag_cmd, flag_ack}), 32'h0);
      rst_n = 1'b1;
      wait_half();

      // slave ignores generator triggers
      pulse(trig_cmd); pulse(trig_rel); wait_half();
      chk(sda_oe == 2'b00, "R4 triggers ignored in slave", 32'(sda_oe), 32'h0);
      chk(flag_cmd == 1'b0, "R4 no command in slave", 32'(flag_cmd), 32'h0);

      // data toggles with clock low
      tb_scl = 1'b0; wait_half();
      tb_lo[0] = 1'b1; wait_half();
      tb_lo[0] = 1'b0; wait_half();
      chk({flag_rel, flag_cmd} == 2'b00, "R3 low-clock data ignored", 32'({flag_rel, flag_cmd}), 32'h0);

      // release then command
      tb_lo[0] = 1'b1; wait_half();
      tb_scl = 1'b1; wait_half();
      tb_lo[0] = 1'b0; wait_half();
      chk({flag_rel, flag_cmd} == 2'b10, "R1 release detected", 32'({flag_rel, flag_cmd}), 32'h2);
      tb_lo[0] = 1'b1; wait_half();
      chk({flag_rel, flag_cmd} == 2'b11, "R2 command detected", 32'({flag_rel, flag_cmd}), 32'h3);

      // address byte, auto ack, busy hold
      slave_bits(8'hA5, 1'b1);
      tb_scl = 1'b0; wait_half();
      tb_lo[0] = 1'b0; wait_half();
      chk(sda_oe[0] == 1'b1, "R7 auto acknowledge", 32'(sda_oe[0]), 32'h1);
      tb_scl = 1'b1; wait_half();
      tb_scl = 1'b0; wait_half(); wait_half();
      chk(sda_oe[0] == 1'b1, "R9 busy held", 32'(sda_oe[0]), 32'h1);
      chk(sda_oe[1] == 1'b0, "R11 unused pin idle", 32'(sda_oe[1]), 32'h0);
      busy_en = 1'b0; wait_half();
      chk(sda_oe[0] == 1'b0, "R9 ready after busy", 32'(sda_oe[0]), 32'h0);

      // command-only byte, no acknowledge
      ack_auto_en = 1'b0;
      tb_scl = 1'b1; wait_half();
      tb_lo[0] = 1'b1; wait_half();
      chk({flag_rel, flag_cmd} == 2'b01, "R10 release cleared by byte", 32'({flag_rel, flag_cmd}), 32'h1);
      slave_bits(8'h3C, 1'b0);
      tb_scl = 1'b0; wait_half();
      tb_lo[0] = 1'b0; wait_half();
      chk(sda_oe[0] == 1'b0, "R8 no ack without trigger", 32'(sda_oe[0]), 32'h0);
      tb_scl = 1'b1; wait_half();
      tb_scl = 1'b0; wait_half();

      // command byte with triggered acknowledge
      tb_scl = 1'b1; wait_half();
      tb_lo[0] = 1'b1; wait_half();
      pulse(trig_ack);
      slave_bits(8'h81, 1'b0);
      tb_scl = 1'b0; wait_half();
      tb_lo[0] = 1'b0; wait_half();
      chk(sda_oe[0] == 1'b1, "R8 triggered ack", 32'(sda_oe[0]), 32'h1);
      tb_scl = 1'b1; wait_half();
      tb_scl = 1'b0; wait_half();
      chk(sda_oe[0] == 1'b0, "R7 ack lasts one slot", 32'(sda_oe[0]), 32'h0);

      // master on pin 1
      role_master = 1'b1; pin_sel = 1'b1; busy_en = 1'b1;
      tb_scl = 1'b1; wait_half();
      pulse(trig_cmd); wait_half();
      chk(sda_oe == 2'b10, "R4 command drive on pin 1", 32'(sda_oe), 32'h2);
      pulse(trig_rel); wait_half();
      chk({flag_rel, flag_cmd} == 2'b10, "R4 generated release", 32'({flag_rel, flag_cmd}), 32'h2);
      chk(sda_oe == 2'b00, "R4 line released", 32'(sda_oe), 32'h0);
      pulse(trig_cmd); wait_half();
      chk(flag_cmd == 1'b1, "R4 generated command", 32'(flag_cmd), 32'h1);

      master_bits(8'h5A, 1'b1);
      tb_scl = 1'b0; wait_half();
      chk(sda_oe[1] == 1'b0, "R5 line released for ack slot", 32'(sda_oe[1]), 32'h0);
      tb_lo[1] = 1'b1; wait_half();
      tb_scl = 1'b1; wait_half();
      chk(flag_ack == 1'b1, "R6 ack detected", 32'(flag_ack), 32'h1);
      tb_scl = 1'b0; wait_half();
      tb_lo[1] = 1'b0; wait_half();
      chk(sda_oe == 2'b00, "R9 no busy in master role", 32'(sda_oe), 32'h0);

      tb_scl = 1'b1; wait_half();
      master_bits(8'hFF, 1'b0);
      chk(flag_ack == 1'b0, "R6 flag cleared by load", 32'(flag_ack), 32'h0);
      tb_scl = 1'b0; wait_half(); wait_half();
      tb_scl = 1'b1; wait_half();
      chk(flag_ack == 1'b0, "R6 no ack when line high", 32'(flag_ack), 32'h0);
      tb_scl = 1'b0; wait_half();
      chk(adv == 8, "R5 advance count", 32'(adv), 32'd8);
      chk(sb_q.size() == 0, "R10 all bytes seen", 32'(sb_q.size()), 32'h0);
      report();
   end
endmodule